// File: doc/BRIEF.md
# Sparse Coordinate-List Spiking Convolution Layer

This block computes one convolutional layer of a streaming spiking neural network. Its nonzero weights sit in a fixed internal table, one entry per weight. Each entry gives a row index, a column offset, a signed 16-bit value and a valid bit. The row index encodes both the output channel and the input channel. The engine visits the table in order, once per timestep. During the first input-channel-count iterations of each timestep, it takes one input spike vector per iteration from an upstream valid/ready stream. It keeps these vectors in a small local bank.

When an entry starts a new output channel, the engine fetches that channel's membrane vector from an internal state memory and scales it by a leak factor. It then adds the entry's weight into every output position whose matching input spike bit is set. When an entry is the last one for its channel, the engine compares each lane against a threshold. Lanes that fire lose a fixed amount (soft reset). The spike vector leaves on a downstream valid/ready stream, tagged with its channel number, and the updated membrane vector goes back to state memory.

The sequence is fixed when the layer is built. Padding entries at the tail of the table make the iteration count a constant. A start pulse clears all membrane state, and a done flag marks the end of the last timestep.

Top module: `sparse_spike_layer`

## Requirements
- R1: While reset is high and right after it is released, `out_valid`, `in_ready` and `done` are 0.
- R2: `in_ready` is high only while the engine waits at table positions 0 to IC-1 of a timestep. Exactly IC beats are accepted per timestep, and beat k becomes input channel k. `in_ready` is first raised OC clock edges after the edge that samples `start`.
- R3: An entry with row index r belongs to output channel r / IC and input channel r % IC. Its value is added to lane p only when bit p + column offset of that input channel's vector is 1 (bit 0 is position 0).
- R4: On the first valid entry of a channel in a timestep, the channel's stored lanes are replaced by floor(V * ALPHA / 2^15), with ALPHA in Q0.15. Membrane state carries over from one timestep to the next.
- R5: Every addition and subtraction on a lane saturates at +32767 and -32768.
- R6: On the last entry of a channel, spike bit p is 1 when lane p is strictly greater than VTH. Each firing lane is reduced by THETA, and the result is stored back.
- R7: Each timestep emits exactly one spike vector per output channel, in ascending channel order, with `out_ch` giving the channel.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_spk` and `out_ch` hold their values.
- R9: Padding entries (valid bit 0, placed after all valid entries) neither accumulate nor write state. Each one costs two cycles, so `done` rises 2·NPAD+1 edges after the edge that accepts the final spike vector.
- R10: `start` clears every channel's membrane state to zero and clears `done`. A repeated run with the same inputs produces the same outputs. While `done` is high, neither stream is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run: clears state, then NT timesteps |
| in_valid | input | 1 | Input spike vector valid |
| in_ready | output | 1 | Engine accepts an input spike vector |
| in_spk | input | NPOS+KW-1 | Input spike vector of one input channel |
| out_valid | output | 1 | Output spike vector valid |
| out_ready | input | 1 | Downstream accepts the spike vector |
| out_spk | output | NPOS | Output spike vector |
| out_ch | output | clog2(OC) | Output channel of the spike vector |
| done | output | 1 | Run finished; cleared by start |

## Verification
Every result of this engine has a fixed due cycle. `in_ready` rises OC edges after the start edge. A spike vector appears one edge after the accumulation of its channel's last entry and then holds until it is accepted. `done` follows 2·NPAD+1 edges after the final acceptance. The bench drives inputs and samples outputs on falling edges. It counts edges from start and from the final handshake to check `in_ready` and `done` in the exact cycle they are due, one edge early as well as on time. The spike vectors and channels are compared at each handshake against a per-timestep model built from the requirements. This includes a saturating lane, a forced stall, and a second run that must repeat the first run's outputs.

// File: rtl/slw_pkg.sv
`timescale 1ns/1ps
package slw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_IN, ST_LEAK, ST_ACC, ST_FIRE, ST_OUT, ST_NEXT
  } slw_state_e;

  typedef enum logic [1:0] {
    OP_HOLD, OP_LEAK, OP_ACC, OP_FIRE
  } lane_op_e;
endpackage

// File: rtl/slw_wrom.sv
`timescale 1ns/1ps
module slw_wrom #(
  parameter int IC       = 2,
  parameter int LIST_LEN = 8,
  parameter int DW       = 16,
  parameter int OCW      = 2,
  parameter int ICW      = 1,
  parameter int CIW      = 2,
  parameter int IDXW     = 3,
  parameter int W_RI  [LIST_LEN] = '{0, 1, 3, 2, 4, 5, 0, 0},
  parameter int W_CI  [LIST_LEN] = '{0, 2, 1, 0, 1, 0, 0, 0},
  parameter int W_VAL [LIST_LEN] = '{60, 50, -40, 90, 20000, 20000, 0, 0},
  parameter int W_VLD [LIST_LEN] = '{1, 1, 1, 1, 1, 1, 0, 0}
) (
  input  logic [IDXW-1:0]       idx,
  output logic                  e_vld,
  output logic                  e_last,
  output logic [OCW-1:0]        e_oc,
  output logic [ICW-1:0]        e_ic,
  output logic [CIW-1:0]        e_ci,
  output logic signed [DW-1:0]  e_val
);
  logic [OCW-1:0]       r_oc  [LIST_LEN];
  logic [ICW-1:0]       r_ic  [LIST_LEN];
  logic [CIW-1:0]       r_ci  [LIST_LEN];
  logic signed [DW-1:0] r_val [LIST_LEN];
  logic [LIST_LEN-1:0]  r_vld;
  logic [LIST_LEN-1:0]  r_last;

  // Row index split into output and input channel at elaboration time.
  for (genvar g = 0; g < LIST_LEN; g++) begin : g_ent
    assign r_oc[g]  = OCW'(W_RI[g] / IC);
    assign r_ic[g]  = ICW'(W_RI[g] % IC);
    assign r_ci[g]  = CIW'(W_CI[g]);
    assign r_val[g] = DW'(W_VAL[g]);
    assign r_vld[g] = (W_VLD[g] != 0);
  end

  // An entry closes its channel when the following entry is padding,
  // belongs to another channel, or does not exist.
  for (genvar g = 0; g < LIST_LEN; g++) begin : g_last
    if (g == LIST_LEN - 1) begin : g_tail
      assign r_last[g] = r_vld[g];
    end else begin : g_body
      assign r_last[g] = r_vld[g] && (!r_vld[g+1] || (r_oc[g+1] != r_oc[g]));
    end
  end

  assign e_vld  = r_vld[idx];
  assign e_last = r_last[idx];
  assign e_oc   = r_oc[idx];
  assign e_ic   = r_ic[idx];
  assign e_ci   = r_ci[idx];
  assign e_val  = r_val[idx];
endmodule

// File: rtl/slw_ifm_buf.sv
`timescale 1ns/1ps
module slw_ifm_buf #(
  parameter int IC   = 2,
  parameter int IN_W = 6,
  parameter int ICW  = 1
) (
  input  logic            clk,
  input  logic            we,
  input  logic [ICW-1:0]  wch,
  input  logic [IN_W-1:0] wdata,
  input  logic [ICW-1:0]  rch,
  output logic [IN_W-1:0] rdata
);
  logic [IN_W-1:0] bank [IC];

  always_ff @(posedge clk) begin
    if (we) bank[wch] <= wdata;
  end

  assign rdata = bank[rch];
endmodule

// File: rtl/slw_vmem.sv
`timescale 1ns/1ps
module slw_vmem #(
  parameter int DEPTH = 3,
  parameter int WIDTH = 64,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/slw_lane.sv
`timescale 1ns/1ps
module slw_lane
  import slw_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ALPHA = 16384,
  parameter int VTH   = 100,
  parameter int THETA = 100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  lane_op_e             op,
  input  logic                 gate,
  input  logic signed [DW-1:0] w,
  input  logic [DW-1:0]        rdata,
  output logic [DW-1:0]        v_post,
  output logic                 fire
);
  localparam logic [DW-1:0]        ALPHA_V   = DW'(ALPHA);
  localparam logic signed [DW-1:0] VTH_V     = DW'(VTH);
  localparam logic signed [DW-1:0] NEG_THETA = DW'(-THETA);
  localparam logic signed [DW-1:0] MAXV      = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV      = {1'b1, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] sat_add(input logic signed [DW-1:0] a,
                                                   input logic signed [DW-1:0] b);
    logic [DW:0] s;
    s = {a[DW-1], a} + {b[DW-1], b};
    if (s[DW] != s[DW-1]) return s[DW] ? MINV : MAXV;
    return s[DW-1:0];
  endfunction

  logic signed [DW-1:0]   v;
  logic signed [2*DW:0]   prod;
  logic signed [DW-1:0]   leak;
  logic signed [DW-1:0]   post;

  assign prod   = $signed(rdata) * $signed({1'b0, ALPHA_V});
  assign leak   = DW'(prod >>> (DW - 1));
  assign fire   = (v > VTH_V);
  assign post   = fire ? sat_add(v, NEG_THETA) : v;
  assign v_post = post;

  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0;
    end else begin
      unique case (op)
        OP_LEAK: v <= leak;
        OP_ACC:  if (gate) v <= sat_add(v, w);
        OP_FIRE: v <= post;
        default: v <= v;
      endcase
    end
  end
endmodule

// File: rtl/sparse_spike_layer.sv
`timescale 1ns/1ps
module sparse_spike_layer
  import slw_pkg::*;
#(
  parameter int IC       = 2,
  parameter int OC       = 3,
  parameter int NPOS     = 4,
  parameter int KW       = 3,
  parameter int NT       = 3,
  parameter int LIST_LEN = 8,
  parameter int DW       = 16,
  parameter int ALPHA    = 16384,
  parameter int VTH      = 100,
  parameter int THETA    = 100,
  parameter int W_RI  [LIST_LEN] = '{0, 1, 3, 2, 4, 5, 0, 0},
  parameter int W_CI  [LIST_LEN] = '{0, 2, 1, 0, 1, 0, 0, 0},
  parameter int W_VAL [LIST_LEN] = '{60, 50, -40, 90, 20000, 20000, 0, 0},
  parameter int W_VLD [LIST_LEN] = '{1, 1, 1, 1, 1, 1, 0, 0}
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [NPOS+KW-2:0]                   in_spk,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [NPOS-1:0]                      out_spk,
  output logic [((OC > 1) ? $clog2(OC) : 1)-1:0] out_ch,
  output logic                                 done
);
  localparam int IN_W  = NPOS + KW - 1;
  localparam int OCW   = (OC > 1) ? $clog2(OC) : 1;
  localparam int ICW   = (IC > 1) ? $clog2(IC) : 1;
  localparam int CIW   = (KW > 1) ? $clog2(KW) : 1;
  localparam int IDXW  = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1;
  localparam int TW    = (NT > 1) ? $clog2(NT) : 1;
  localparam int WORDW = NPOS * DW;

  slw_state_e          state;
  logic [IDXW-1:0]     idx;
  logic [TW-1:0]       tstep;
  logic [OCW-1:0]      clr_cnt;
  logic [OCW-1:0]      pre_oc;
  logic                pre_vld;

  logic                e_vld, e_last;
  logic [OCW-1:0]      e_oc;
  logic [ICW-1:0]      e_ic;
  logic [CIW-1:0]      e_ci;
  logic signed [DW-1:0] e_val;

  logic                need_in, first;
  logic [IN_W-1:0]     rd_vec;
  logic [NPOS-1:0]     sh_vec;
  logic [WORDW-1:0]    rd_word, post_word, wr_word;
  logic [NPOS-1:0]     fire_vec;
  logic                mem_we;
  logic [OCW-1:0]      mem_waddr;
  lane_op_e            lane_op;

  slw_wrom #(
    .IC(IC), .LIST_LEN(LIST_LEN), .DW(DW), .OCW(OCW), .ICW(ICW), .CIW(CIW),
    .IDXW(IDXW), .W_RI(W_RI), .W_CI(W_CI), .W_VAL(W_VAL), .W_VLD(W_VLD)
  ) u_wrom (
    .idx(idx), .e_vld(e_vld), .e_last(e_last), .e_oc(e_oc),
    .e_ic(e_ic), .e_ci(e_ci), .e_val(e_val)
  );

  assign need_in  = ({1'b0, idx} < (IDXW+1)'(IC));
  assign in_ready = (state == ST_IN) && need_in;
  assign first    = !pre_vld || (e_oc != pre_oc);

  slw_ifm_buf #(.IC(IC), .IN_W(IN_W), .ICW(ICW)) u_ifm (
    .clk(clk), .we(in_ready && in_valid), .wch(ICW'(idx)), .wdata(in_spk),
    .rch(e_ic), .rdata(rd_vec)
  );

  // Lane p is gated by spike bit p + column offset of the entry's channel.
  assign sh_vec = NPOS'(rd_vec >> e_ci);

  assign mem_we    = (state == ST_CLEAR) || (state == ST_FIRE);
  assign mem_waddr = (state == ST_CLEAR) ? clr_cnt : e_oc;
  assign wr_word   = (state == ST_CLEAR) ? '0 : post_word;

  slw_vmem #(.DEPTH(OC), .WIDTH(WORDW), .AW(OCW)) u_vmem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_word),
    .raddr(e_oc), .rdata(rd_word)
  );

  always_comb begin
    unique case (state)
      ST_LEAK: lane_op = OP_LEAK;
      ST_ACC:  lane_op = OP_ACC;
      ST_FIRE: lane_op = OP_FIRE;
      default: lane_op = OP_HOLD;
    endcase
  end

  for (genvar p = 0; p < NPOS; p++) begin : g_lane
    slw_lane #(.DW(DW), .ALPHA(ALPHA), .VTH(VTH), .THETA(THETA)) u_lane (
      .clk(clk), .rst(rst), .op(lane_op), .gate(sh_vec[p]), .w(e_val),
      .rdata(rd_word[p*DW +: DW]), .v_post(post_word[p*DW +: DW]),
      .fire(fire_vec[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      tstep     <= '0;
      clr_cnt   <= '0;
      pre_oc    <= '0;
      pre_vld   <= 1'b0;
      out_valid <= 1'b0;
      out_spk   <= '0;
      out_ch    <= '0;
      done      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            done    <= 1'b0;
            clr_cnt <= '0;
            state   <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          if (clr_cnt == OCW'(OC - 1)) begin
            idx     <= '0;
            tstep   <= '0;
            pre_vld <= 1'b0;
            state   <= ST_IN;
          end else begin
            clr_cnt <= clr_cnt + 1'b1;
          end
        end
        ST_IN: begin
          if (!need_in || in_valid) begin
            if (!e_vld)     state <= ST_NEXT;
            else if (first) state <= ST_LEAK;
            else            state <= ST_ACC;
          end
        end
        ST_LEAK: begin
          pre_oc  <= e_oc;
          pre_vld <= 1'b1;
          state   <= ST_ACC;
        end
        ST_ACC: begin
          state <= e_last ? ST_FIRE : ST_NEXT;
        end
        ST_FIRE: begin
          out_valid <= 1'b1;
          out_spk   <= fire_vec;
          out_ch    <= e_oc;
          state     <= ST_OUT;
        end
        ST_OUT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (idx == IDXW'(LIST_LEN - 1)) begin
            idx     <= '0;
            pre_vld <= 1'b0;
            if (tstep == TW'(NT - 1)) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              tstep <= tstep + 1'b1;
              state <= ST_IN;
            end
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_IN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sparse_spike_layer_chk.sv
`timescale 1ns/1ps
module sparse_spike_layer_chk #(
  parameter int NPOS = 4,
  parameter int OCW  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [NPOS-1:0] out_spk,
  input logic [OCW-1:0]  out_ch,
  input logic            done
);
  logic [OCW-1:0] last_ch;
  logic           seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_ch <= '0;
      seen    <= 1'b0;
    end else if (out_valid && out_ready) begin
      last_ch <= out_ch;
      seen    <= 1'b1;
    end
  end

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_spk) && $stable(out_ch)));

  assert_ch_order_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && seen) |-> ((out_ch == '0) || (out_ch > last_ch)));

  assert_streams_apart_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!in_ready && !out_valid));
endmodule

bind sparse_spike_layer sparse_spike_layer_chk #(.NPOS(NPOS), .OCW(OCW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_spk(out_spk), .out_ch(out_ch), .done(done)
);

// File: tb/sparse_spike_layer_bench.sv
`timescale 1ns/1ps
module sparse_spike_layer_bench;
  localparam int IC = 2, OC = 3, NPOS = 4, KW = 3, NT = 3, LL = 8, NPAD = 2;
  localparam int IN_W = NPOS + KW - 1;
  localparam int OCW = 2;
  localparam int ALPHA = 16384, VTH = 100, THETA = 100;
  localparam int W_RI  [LL] = '{0, 1, 3, 2, 4, 5, 0, 0};
  localparam int W_CI  [LL] = '{0, 2, 1, 0, 1, 0, 0, 0};
  localparam int W_VAL [LL] = '{60, 50, -40, 90, 20000, 20000, 0, 0};
  localparam int W_VLD [LL] = '{1, 1, 1, 1, 1, 1, 0, 0};
  // Input spike vectors: timestep-major, input channel minor.
  localparam logic [IN_W-1:0] STIM [NT*IC] = '{
    6'b101101, 6'b110011, 6'b111111, 6'b000000, 6'b010101, 6'b101010};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [IN_W-1:0] in_spk = '0;
  logic in_ready, out_valid, done;
  logic [NPOS-1:0] out_spk;
  logic [OCW-1:0] out_ch;
  logic [NPOS-1:0] exp_spk [NT][OC];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sparse_spike_layer #(
    .IC(IC), .OC(OC), .NPOS(NPOS), .KW(KW), .NT(NT), .LIST_LEN(LL), .DW(16),
    .ALPHA(ALPHA), .VTH(VTH), .THETA(THETA),
    .W_RI(W_RI), .W_CI(W_CI), .W_VAL(W_VAL), .W_VLD(W_VLD)
  ) u_sparse_spike_layer (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_spk(in_spk), .out_valid(out_valid), .out_ready(out_ready),
    .out_spk(out_spk), .out_ch(out_ch), .done(done)
  );

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int sat(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // Reference per requirements R3, R4, R5, R6, R9.
  task automatic build_model();
    int v [OC][NPOS];
    for (int o = 0; o < OC; o++)
      for (int p = 0; p < NPOS; p++) v[o][p] = 0;
    for (int t = 0; t < NT; t++) begin
      int pre;
      pre = -1;
      for (int j = 0; j < LL; j++) begin
        int oc, ic;
        bit last;
        if (W_VLD[j] == 0) continue;
        oc = W_RI[j] / IC;
        ic = W_RI[j] % IC;
        if (oc != pre) begin
          for (int p = 0; p < NPOS; p++) v[oc][p] = (v[oc][p] * ALPHA) >>> 15;
          pre = oc;
        end
        for (int p = 0; p < NPOS; p++)
          if (STIM[t*IC+ic][p+W_CI[j]]) v[oc][p] = sat(v[oc][p] + W_VAL[j]);
        last = (j == LL-1) || (W_VLD[j+1] == 0) || (W_RI[j+1] / IC != oc);
        if (last) begin
          for (int p = 0; p < NPOS; p++) begin
            if (v[oc][p] > VTH) begin
              exp_spk[t][oc][p] = 1'b1;
              v[oc][p] = sat(v[oc][p] - THETA);
            end else begin
              exp_spk[t][oc][p] = 1'b0;
            end
          end
        end
      end
    end
  endtask

  task automatic feeder();
    for (int t = 0; t < NT; t++) begin
      for (int c = 0; c < IC; c++) begin
        in_valid = 1'b1;
        in_spk   = STIM[t*IC+c];
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
  endtask

  task automatic consumer(input int run);
    for (int t = 0; t < NT; t++) begin
      for (int o = 0; o < OC; o++) begin
        while (!out_valid) @(negedge clk);
        if (run == 0 && t == 0 && o == 0) begin
          logic [NPOS-1:0] held;
          held = out_spk;
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 valid held", int'(out_valid), 1);
            chk("R8 data held", int'(out_spk), int'(held));
          end
        end
        chk("R7 channel", int'(out_ch), o);
        chk("R2 in_ready low at output", int'(in_ready), 0);
        chk((o == 2) ? "R5 R6 spikes" : (t == 0) ? "R3 R6 spikes" : "R4 R6 spikes",
            int'(out_spk), int'(exp_spk[t][o]));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
      end
    end
    // Now one falling edge after the final acceptance edge.
    for (int k = 0; k < 2*NPAD; k++) @(negedge clk);
    chk("R9 done not early", int'(done), 0);
    @(negedge clk);
    chk("R9 done due", int'(done), 1);
    chk("R10 streams quiet at done", int'(in_ready || out_valid), 0);
  endtask

  task automatic run_layer(input int run);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done cleared by start", int'(done), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 in_ready low while clearing", int'(in_ready), 0);
    @(negedge clk);
    chk("R2 in_ready after clear", int'(in_ready), 1);
    fork
      feeder();
      consumer(run);
    join
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    build_model();
    @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_ready in reset", int'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R2 in_ready idle", int'(in_ready), 0);
    run_layer(0);
    // Second run must repeat the first: state cleared by start (R10).
    run_layer(1);
    chk("R10 done holds when idle", int'(done), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule